// File: doc/BRIEF.md
# Single-Cycle Seven-Instruction Processor Core

This block is a small processor core that completes one instruction on every clock edge. It fetches a 32-bit word from an external instruction memory at the current program counter. It decodes the word and reads two operands from a 32-entry register file. It then computes a result with a three-function ALU and writes that result, or a word loaded from the external data memory, back into the register file. The program counter, the register file and the data-memory write all update on the same rising edge.

The core supports seven operations: register add and subtract, OR with an immediate, load word, store word, branch on equal, and an absolute jump. Both memories sit outside the block. The instruction memory is read combinationally from `imem_addr`. The data memory is read combinationally from `dmem_addr` and written on the rising edge while `dmem_we` is high. The core drives `dmem_we` high only for a store.

Top module: `lite_core`

## Requirements
- R1: While `rst_n` is low, the program counter and every register clear to zero. On the first cycle after reset, `imem_addr` is 0.
- R2: Opcode 000000 with funct 100001 writes rs + rt into rd. Funct 100011 writes rs − rt into rd. Both results wrap modulo 2^32.
- R3: Opcode 001101 writes rs OR the immediate (bits 15:0, zero-extended) into rt.
- R4: Opcode 100011 drives `dmem_addr` with rs plus the sign-extended immediate, and writes `dmem_rdata` into rt.
- R5: Opcode 101011 drives `dmem_addr` with rs plus the sign-extended immediate, drives `dmem_wdata` with rt, and raises `dmem_we`. No other instruction raises `dmem_we`.
- R6: Opcode 000100 compares rs and rt. If they are equal, the next PC is PC + 4 + (sign-extended immediate × 4). Otherwise the next PC is PC + 4.
- R7: Opcode 000010 sets the next PC to bits 31:28 of PC + 4, followed by the 26-bit target (bits 25:0), followed by two zero bits.
- R8: Every instruction other than a branch or a jump advances the PC by 4.
- R9: Register 0 always reads as zero. Any write to it is discarded.
- R10: An opcode outside the set, or an opcode-000000 word whose funct is neither of the two listed, writes no register and no memory, and advances the PC by 4.
- R11: Opcode-000000 instructions write the register named in bits 15:11 and leave the one in bits 20:16 untouched. Immediate-form instructions write the register named in bits 20:16.
- R12: `imem_addr` bits 1:0 are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| imem_addr | output | 32 | Byte address of the current instruction |
| imem_data | input | 32 | Instruction word read at `imem_addr` |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Data-memory write strobe |
| dmem_rdata | input | 32 | Load data read at `dmem_addr` |

## Verification
The bench builds the core with its default 32-bit data width. It models both memories as small arrays indexed by low address bits. It runs eight 32-bit operand patterns (zero, one, all-ones, the sign boundary on each side, and mixed words) through add and subtract in every ordered pair, so that carry-out, borrow and sign wrap are all reached. Four immediates, including one with the top bit set, go through the OR against each pattern, which exposes any sign extension where zero extension belongs. Separate runs cover negative load and store offsets, taken and untaken branches both forward and backward, the jump target, writes aimed at register 0, and unrecognised encodings.

// File: rtl/lite_core_pkg.sv
package lite_core_pkg;

    localparam int INSTR_W   = 32;
    localparam int REG_AW    = 5;
    localparam int REG_COUNT = 1 << REG_AW;
    localparam int IMM_W     = 16;
    localparam int TGT_W     = 26;

    localparam logic [5:0] OP_RTYPE = 6'b000000;
    localparam logic [5:0] OP_ORI   = 6'b001101;
    localparam logic [5:0] OP_LW    = 6'b100011;
    localparam logic [5:0] OP_SW    = 6'b101011;
    localparam logic [5:0] OP_BEQ   = 6'b000100;
    localparam logic [5:0] OP_JMP   = 6'b000010;

    localparam logic [5:0] FN_ADDU  = 6'b100001;
    localparam logic [5:0] FN_SUBU  = 6'b100011;

    typedef enum logic [2:0] {
        K_NOP,
        K_ADDU,
        K_SUBU,
        K_ORI,
        K_LOAD,
        K_STORE,
        K_BEQ,
        K_JUMP
    } instr_kind_e;

    typedef enum logic [1:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_OR
    } alu_op_e;

    typedef struct packed {
        logic    dst_rd;
        logic    src_imm;
        logic    ext_sign;
        alu_op_e alu_op;
        logic    wb_mem;
        logic    reg_we;
        logic    mem_we;
        logic    branch;
        logic    jump;
    } ctrl_t;

endpackage

// File: rtl/lite_core_decode.sv
module lite_core_decode
    import lite_core_pkg::*;
(
    input  logic [5:0] op,
    input  logic [5:0] funct,
    output instr_kind_e kind,
    output ctrl_t      ctrl
);

    always_comb begin
        kind = K_NOP;
        unique case (op)
            OP_RTYPE: begin
                case (funct)
                    FN_ADDU: kind = K_ADDU;
                    FN_SUBU: kind = K_SUBU;
                    default: kind = K_NOP;
                endcase
            end
            OP_ORI:  kind = K_ORI;
            OP_LW:   kind = K_LOAD;
            OP_SW:   kind = K_STORE;
            OP_BEQ:  kind = K_BEQ;
            OP_JMP:  kind = K_JUMP;
            default: kind = K_NOP;
        endcase
    end

    always_comb begin
        ctrl = '0;
        ctrl.alu_op = ALU_ADD;
        unique case (kind)
            K_ADDU: begin
                ctrl.dst_rd = 1'b1;
                ctrl.reg_we = 1'b1;
                ctrl.alu_op = ALU_ADD;
            end
            K_SUBU: begin
                ctrl.dst_rd = 1'b1;
                ctrl.reg_we = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            K_ORI: begin
                ctrl.src_imm = 1'b1;
                ctrl.reg_we  = 1'b1;
                ctrl.alu_op  = ALU_OR;
            end
            K_LOAD: begin
                ctrl.src_imm  = 1'b1;
                ctrl.ext_sign = 1'b1;
                ctrl.wb_mem   = 1'b1;
                ctrl.reg_we   = 1'b1;
            end
            K_STORE: begin
                ctrl.src_imm  = 1'b1;
                ctrl.ext_sign = 1'b1;
                ctrl.mem_we   = 1'b1;
            end
            K_BEQ: begin
                ctrl.alu_op = ALU_SUB;
                ctrl.branch = 1'b1;
            end
            K_JUMP: begin
                ctrl.jump = 1'b1;
            end
            K_NOP: begin
                ctrl = '0;
            end
        endcase
    end

endmodule

// File: rtl/lite_core_regfile.sv
module lite_core_regfile #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ra,
    input  logic [ADDR_W-1:0] rb,
    input  logic [ADDR_W-1:0] wa,
    input  logic              we,
    input  logic [DATA_W-1:0] wd,
    output logic [DATA_W-1:0] bus_a,
    output logic [DATA_W-1:0] bus_b
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_reg
        if (g == 0) begin : g_zero
            assign q[g] = '0;
        end else begin : g_flop
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q[g] <= '0;
                end else if (we && (wa == ADDR_W'(g))) begin
                    q[g] <= wd;
                end
            end
        end
    end

    assign bus_a = q[ra];
    assign bus_b = q[rb];

endmodule

// File: rtl/lite_core_alu.sv
module lite_core_alu
    import lite_core_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y,
    output logic              zero
);

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_OR:  y = a | b;
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/lite_core_next_pc.sv
module lite_core_next_pc #(
    parameter int PC_W  = 32,
    parameter int IMM_W = 16,
    parameter int TGT_W = 26
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [IMM_W-1:0] imm,
    input  logic [TGT_W-1:0] target,
    input  logic             branch,
    input  logic             equal,
    input  logic             jump,
    output logic [PC_W-1:0]  pc_next
);

    localparam int HI_W = PC_W - TGT_W - 2;

    logic [PC_W-1:0] pc_seq;
    logic [PC_W-1:0] br_off;
    logic [PC_W-1:0] pc_br;
    logic [PC_W-1:0] pc_jmp;

    assign pc_seq = pc + PC_W'(4);
    assign br_off = {{(PC_W-IMM_W-2){imm[IMM_W-1]}}, imm, 2'b00};
    assign pc_br  = pc_seq + br_off;
    assign pc_jmp = {pc_seq[PC_W-1 -: HI_W], target, 2'b00};

    always_comb begin
        if (jump) begin
            pc_next = pc_jmp;
        end else if (branch && equal) begin
            pc_next = pc_br;
        end else begin
            pc_next = pc_seq;
        end
    end

endmodule

// File: rtl/lite_core.sv
module lite_core
    import lite_core_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [31:0]       imem_addr,
    input  logic [31:0]       imem_data,
    output logic [DATA_W-1:0] dmem_addr,
    output logic [DATA_W-1:0] dmem_wdata,
    output logic              dmem_we,
    input  logic [DATA_W-1:0] dmem_rdata
);

    localparam int PC_W = INSTR_W;

    logic [PC_W-1:0]   pc_q;
    logic [PC_W-1:0]   pc_d;

    logic [5:0]        f_op;
    logic [REG_AW-1:0] f_rs;
    logic [REG_AW-1:0] f_rt;
    logic [REG_AW-1:0] f_rd;
    logic [5:0]        f_funct;
    logic [IMM_W-1:0]  f_imm;
    logic [TGT_W-1:0]  f_tgt;

    instr_kind_e       kind;
    ctrl_t             ctrl;

    logic [DATA_W-1:0] bus_a;
    logic [DATA_W-1:0] bus_b;
    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] alu_b;
    logic [DATA_W-1:0] alu_y;
    logic              alu_zero;
    logic [DATA_W-1:0] wb_data;
    logic [REG_AW-1:0] wb_addr;

    logic              unused_fields;

    assign f_op    = imem_data[31:26];
    assign f_rs    = imem_data[25:21];
    assign f_rt    = imem_data[20:16];
    assign f_rd    = imem_data[15:11];
    assign f_funct = imem_data[5:0];
    assign f_imm   = imem_data[15:0];
    assign f_tgt   = imem_data[25:0];

    assign unused_fields = ^{imem_data[10:6], kind};

    lite_core_decode u_decode (
        .op    (f_op),
        .funct (f_funct),
        .kind  (kind),
        .ctrl  (ctrl)
    );

    lite_core_regfile #(
        .DATA_W (DATA_W),
        .ADDR_W (REG_AW)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .ra    (f_rs),
        .rb    (f_rt),
        .wa    (wb_addr),
        .we    (ctrl.reg_we),
        .wd    (wb_data),
        .bus_a (bus_a),
        .bus_b (bus_b)
    );

    always_comb begin
        if (ctrl.ext_sign) begin
            imm_ext = {{(DATA_W-IMM_W){f_imm[IMM_W-1]}}, f_imm};
        end else begin
            imm_ext = {{(DATA_W-IMM_W){1'b0}}, f_imm};
        end
    end

    assign alu_b = ctrl.src_imm ? imm_ext : bus_b;

    lite_core_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .op   (ctrl.alu_op),
        .a    (bus_a),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign wb_addr = ctrl.dst_rd ? f_rd : f_rt;
    assign wb_data = ctrl.wb_mem ? dmem_rdata : alu_y;

    lite_core_next_pc #(
        .PC_W  (PC_W),
        .IMM_W (IMM_W),
        .TGT_W (TGT_W)
    ) u_npc (
        .pc      (pc_q),
        .imm     (f_imm),
        .target  (f_tgt),
        .branch  (ctrl.branch),
        .equal   (alu_zero),
        .jump    (ctrl.jump),
        .pc_next (pc_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_d;
        end
    end

    assign imem_addr  = pc_q;
    assign dmem_addr  = alu_y;
    assign dmem_wdata = bus_b;
    assign dmem_we    = ctrl.mem_we;

endmodule

// File: rtl/lite_core_chk.sv
module lite_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] imem_addr,
    input logic [31:0] imem_data,
    input logic        dmem_we
);

    localparam logic [5:0] C_SW  = 6'b101011;
    localparam logic [5:0] C_BEQ = 6'b000100;
    localparam logic [5:0] C_J   = 6'b000010;

    // R5
    store_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> (imem_data[31:26] == C_SW));

    // R8
    sequential_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((imem_data[31:26] != C_BEQ) && (imem_data[31:26] != C_J))
        |=> (imem_addr == $past(imem_addr) + 32'd4));

    // R7
    jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_data[31:26] == C_J)
        |=> (imem_addr[27:0] == {$past(imem_data[25:0]), 2'b00}));

    // R6
    beq_same_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((imem_data[31:26] == C_BEQ) && (imem_data[25:21] == imem_data[20:16]))
        |=> (imem_addr == $past(imem_addr) + 32'd4
             + {{14{$past(imem_data[15])}}, $past(imem_data[15:0]), 2'b00}));

    // R12
    word_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        imem_addr[1:0] == 2'b00);

endmodule

bind lite_core lite_core_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .imem_addr (imem_addr),
    .imem_data (imem_data),
    .dmem_we   (dmem_we)
);

// File: tb/tb_lite_core.sv
module tb_lite_core;

    localparam logic [5:0] T_R   = 6'b000000;
    localparam logic [5:0] T_ORI = 6'b001101;
    localparam logic [5:0] T_LW  = 6'b100011;
    localparam logic [5:0] T_SW  = 6'b101011;
    localparam logic [5:0] T_BEQ = 6'b000100;
    localparam logic [5:0] T_J   = 6'b000010;
    localparam logic [5:0] T_ADD = 6'b100001;
    localparam logic [5:0] T_SUB = 6'b100011;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    always #5 clk = ~clk;

    lite_core dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    logic [31:0] imem [256];
    logic [31:0] dmem [64];
    logic [31:0] pat  [8];

    assign imem_data  = imem[imem_addr[9:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
    end

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] cap_pc, cap_addr, cap_wdata;
    logic        cap_we;

    function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [4:0] rd, input logic [5:0] fn);
        return {T_R, rs, rt, rd, 5'b00000, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [31:0] ins);
        imem[imem_addr[9:2]] = ins;
        #1;
        cap_pc    = imem_addr;
        cap_we    = dmem_we;
        cap_addr  = dmem_addr;
        cap_wdata = dmem_wdata;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic read_reg(input logic [4:0] r, output logic [31:0] val);
        step(enc_i(T_SW, 5'd0, r, 16'h0080));
        val = cap_wdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, w, p0;
        logic [15:0] imms [4];
        imms[0] = 16'h0000; imms[1] = 16'h8001; imms[2] = 16'hFFFF; imms[3] = 16'h1234;
        pat[0] = 32'h0000_0000; pat[1] = 32'h0000_0001; pat[2] = 32'hFFFF_FFFF;
        pat[3] = 32'h8000_0000; pat[4] = 32'h7FFF_FFFF; pat[5] = 32'h1234_5678;
        pat[6] = 32'hDEAD_BEEF; pat[7] = 32'h0001_0000;
        for (int k = 0; k < 256; k++) imem[k] = 32'h0;
        for (int k = 0; k < 64; k++) dmem[k] = (k < 8) ? pat[k] : 32'h0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1 pc after reset", imem_addr, 32'h0);
        check("R1 no write after reset", {31'b0, dmem_we}, 32'h0);
        @(negedge clk);
        read_reg(5'd5, v);
        check("R1 register cleared", v, 32'h0);
        check("R5 store strobe", {31'b0, cap_we}, 32'h1);
        check("R5 store address", cap_addr, 32'h80);

        // R2 and R4: all operand pairs through load, add and subtract
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                step(enc_i(T_LW, 5'd0, 5'd1, 16'(4 * i)));
                step(enc_i(T_LW, 5'd0, 5'd2, 16'(4 * j)));
                step(enc_r(5'd1, 5'd2, 5'd3, T_ADD));
                step(enc_r(5'd1, 5'd2, 5'd4, T_SUB));
                read_reg(5'd3, v);
                check("R2 add", v, pat[i] + pat[j]);
                read_reg(5'd4, v);
                check("R2 sub", v, pat[i] - pat[j]);
            end
        end

        // R3: OR with zero-extended immediate
        for (int i = 0; i < 8; i++) begin
            for (int m = 0; m < 4; m++) begin
                step(enc_i(T_LW, 5'd0, 5'd1, 16'(4 * i)));
                step(enc_i(T_ORI, 5'd1, 5'd5, imms[m]));
                read_reg(5'd5, v);
                check("R3 ori", v, pat[i] | {16'h0, imms[m]});
            end
        end

        // R11: destination selection
        step(enc_i(T_ORI, 5'd0, 5'd10, 16'h0055));
        step(enc_i(T_ORI, 5'd0, 5'd11, 16'h0066));
        step(enc_r(5'd10, 5'd11, 5'd12, T_ADD));
        read_reg(5'd11, v);
        check("R11 rt untouched by R-type", v, 32'h66);
        read_reg(5'd12, v);
        check("R11 rd written by R-type", v, 32'hBB);
        step(enc_i(T_ORI, 5'd0, 5'd14, 16'h0077));
        step(enc_i(T_LW, 5'd0, 5'd13, 16'h7004));
        read_reg(5'd13, v);
        check("R11 load writes rt", v, pat[1]);
        read_reg(5'd14, v);
        check("R11 load leaves rd-field reg", v, 32'h77);

        // R4: negative offset load
        step(enc_i(T_ORI, 5'd0, 5'd6, 16'h011C));
        step(enc_i(T_LW, 5'd6, 5'd7, 16'hFFF8));
        check("R4 load address", cap_addr, 32'h114);
        check("R5 no strobe on load", {31'b0, cap_we}, 32'h0);
        read_reg(5'd7, v);
        check("R4 load data", v, pat[5]);

        // R5: negative offset store then reload
        step(enc_i(T_SW, 5'd6, 5'd7, 16'hFFFC));
        check("R5 store address", cap_addr, 32'h118);
        check("R5 store data", cap_wdata, pat[5]);
        check("R5 store strobe", {31'b0, cap_we}, 32'h1);
        step(enc_i(T_LW, 5'd6, 5'd8, 16'hFFFC));
        read_reg(5'd8, v);
        check("R5 stored word reloads", v, pat[5]);

        // R9: register 0
        step(enc_i(T_ORI, 5'd0, 5'd0, 16'h1234));
        read_reg(5'd0, v);
        check("R9 ori to r0 discarded", v, 32'h0);
        step(enc_r(5'd7, 5'd7, 5'd0, T_ADD));
        read_reg(5'd0, v);
        check("R9 add to r0 discarded", v, 32'h0);
        step(enc_r(5'd0, 5'd7, 5'd9, T_ADD));
        read_reg(5'd9, v);
        check("R9 r0 reads zero as operand", v, pat[5]);

        // R6: branches
        p0 = imem_addr;
        step(enc_i(T_BEQ, 5'd7, 5'd8, 16'd3));
        check("R6 taken forward", imem_addr, p0 + 32'd16);
        p0 = imem_addr;
        step(enc_i(T_BEQ, 5'd7, 5'd0, 16'd3));
        check("R6 not taken", imem_addr, p0 + 32'd4);
        p0 = imem_addr;
        step(enc_i(T_BEQ, 5'd0, 5'd0, 16'hFFFE));
        check("R6 taken backward", imem_addr, p0 - 32'd4);

        // R7: jump
        p0 = imem_addr;
        step({T_J, 26'h0000040});
        check("R7 jump target", imem_addr, {p0[31:28] + 4'h0, 28'h0000100});

        // R8: sequential advance
        p0 = imem_addr;
        step(enc_i(T_ORI, 5'd0, 5'd15, 16'h0001));
        check("R8 ori advances", imem_addr, p0 + 32'd4);
        p0 = imem_addr;
        step(enc_i(T_SW, 5'd0, 5'd15, 16'h0084));
        check("R8 store advances", imem_addr, p0 + 32'd4);

        // R10: unrecognised encodings
        read_reg(5'd7, w);
        p0 = imem_addr;
        step(enc_i(6'b111111, 5'd0, 5'd7, 16'h0080));
        check("R10 no strobe on bad opcode", {31'b0, cap_we}, 32'h0);
        check("R10 bad opcode advances", imem_addr, p0 + 32'd4);
        read_reg(5'd7, v);
        check("R10 bad opcode no reg write", v, w);
        p0 = imem_addr;
        step(enc_r(5'd0, 5'd0, 5'd7, 6'b100000));
        check("R10 bad funct advances", imem_addr, p0 + 32'd4);
        read_reg(5'd7, v);
        check("R10 bad funct no reg write", v, w);

        // R12: alignment
        check("R12 aligned pc", {30'b0, imem_addr[1:0]}, 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule